// File: doc/BRIEF.md
# Supervisory shutdown and lockout controller

This block decides, every clock, which parts of a switching-regulator controller may run. It watches a sampled supply-voltage code and applies a two-threshold window to it, which yields a power-good flag that cannot chatter near a single trip point. Three asynchronous control requests (a sleep request, a main run enable and an auxiliary-amplifier enable) are synchronized and combined with that flag in a fixed priority order. From this the block produces digital gates for the reference, the oscillator, the output drivers, the error-amplifier output, the auxiliary amplifier and the soft-start discharge clamp.

Sleep wins over everything and darkens the whole controller, the reference and the power-good output included. A low run enable stops only the switching path (oscillator, drivers, error amplifier). The reference, the power-good report and the auxiliary amplifier stay alive. An undervoltage stops the switching path no matter what the enable says. The soft-start clamp is the exact complement of "switching allowed", so every shutdown path also discharges the soft-start node.

Top module: `pwr_sequencer`

## Requirements
- R1: The internal supply-good state goes high only on a valid sample strictly above START_MV (default 4100 mV), and goes low only on a valid sample strictly below STOP_MV (default 3500 mV). Samples equal to a threshold, or lying between the two, leave the state unchanged.
- R2: After reset the outputs are `pgood`=0, `ref_on`=0, `osc_on`=0, `drv_on`=0, `ea_on`=0, `aux_on`=0 and `ss_clamp`=1. The switching gates stay off until a valid sample exceeds START_MV.
- R3: While the synchronized sleep request is high, every gate output and `pgood` are 0 and `ss_clamp` is 1, whatever the values of `run_en` and `aux_req`. The supply-good state is kept through sleep and reappears when sleep is released.
- R4: With sleep low and `run_en` low, `osc_on`, `drv_on` and `ea_on` are 0 and `ss_clamp` is 1. `ref_on` is 1, and `pgood` shows the supply-good state.
- R5: `aux_on` is 1 exactly when the synchronized `aux_req` is high and sleep is low, whatever the values of `run_en` and the supply-good state.
- R6: While the supply-good state is low, `osc_on`, `drv_on` and `ea_on` are 0 and `ss_clamp` is 1.
- R7: With sleep low, `run_en` high and supply good, `osc_on`, `drv_on` and `ea_on` are 1 and `ss_clamp` is 0.
- R8: A change on `sleep_req`, `run_en` or `aux_req` shows on the outputs after exactly SYNC_STAGES+1 rising edges (3 by default, which is 15 ns at 200 MHz). A valid supply sample shows on the outputs after 2 rising edges, counting the edge that captures it. Both delays are well inside a 100 ns driver shut-off bound.
- R9: A supply code presented while `vsup_valid` is 0 has no effect on the supply-good state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| run_en | input | 1 | Asynchronous main run enable, active high |
| aux_req | input | 1 | Asynchronous auxiliary-amplifier enable, active high |
| vsup_mv | input | MV_W (13) | Supply sample, unsigned millivolts |
| vsup_valid | input | 1 | Marks `vsup_mv` as a fresh sample this cycle |
| pgood | output | 1 | Power-good indication |
| ref_on | output | 1 | Reference enable |
| osc_on | output | 1 | Oscillator enable |
| drv_on | output | 1 | Output driver enable |
| ea_on | output | 1 | Error-amplifier output enable |
| ss_clamp | output | 1 | Soft-start discharge switch, 1 = node shorted |
| aux_on | output | 1 | Auxiliary amplifier enable |

## Verification
Two events can reach the output register on the same edge: a run enable that has just come out of the synchronizer, and an undervoltage sample that clears the supply-good state. The bench raises `run_en` and times a sample below STOP_MV so that both land on the same clock. The drivers must never pulse on. `drv_on` must read 0 and `ss_clamp` must read 1 on that edge and on the next one. The latency checks sample the outputs one edge before and on the edge where a change is due, so that a change which comes early or late is seen.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // bit positions of the control requests in the synchronizer vector
    localparam int CTL_SLEEP = 0;
    localparam int CTL_RUN   = 1;
    localparam int CTL_AUX   = 2;
    localparam int CTL_W     = 3;

    typedef struct packed {
        logic ref_on;
        logic pg;
        logic osc_on;
        logic drv_on;
        logic ea_on;
        logic ss_clamp;
        logic aux_on;
    } gate_vec_t;

    localparam gate_vec_t GATES_DARK = '{ref_on: 1'b0, pg: 1'b0, osc_on: 1'b0,
                                         drv_on: 1'b0, ea_on: 1'b0,
                                         ss_clamp: 1'b1, aux_on: 1'b0};

    // priority: sleep > (run enable and supply good) ; aux independent of run/pg
    function automatic gate_vec_t gate_decode(input logic sleep, input logic run,
                                              input logic aux, input logic pg);
        gate_vec_t g;
        logic      switching;
        switching  = !sleep && run && pg;
        g.ref_on   = !sleep;
        g.pg       = pg && !sleep;
        g.osc_on   = switching;
        g.drv_on   = switching;
        g.ea_on    = switching;
        g.ss_clamp = !switching;
        g.aux_on   = aux && !sleep;
        return g;
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R8
    end
endmodule

// File: rtl/pwr_seq_uvlo.sv
module pwr_seq_uvlo #(
    parameter int MV_W     = 13,
    parameter int START_MV = 4100,
    parameter int STOP_MV  = 3500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MV_W-1:0] smp_mv,
    input  logic            smp_valid,
    output logic            pg
);
    localparam logic [MV_W-1:0] START_C = MV_W'(START_MV);
    localparam logic [MV_W-1:0] STOP_C  = MV_W'(STOP_MV);

    logic pg_q;
    logic above_start;
    logic below_stop;

    assign above_start = smp_valid && (smp_mv > START_C);
    assign below_stop  = smp_valid && (smp_mv < STOP_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q <= 1'b0;
        end else if (!pg_q && above_start) begin
            pg_q <= 1'b1;
        end else if (pg_q && below_stop) begin
            pg_q <= 1'b0;
        end
    end

    assign pg = pg_q;

    AST_PG_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_q) |-> $past(smp_valid && smp_mv > START_C)); // R1
    AST_PG_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(pg_q) |-> $past(smp_valid && smp_mv < STOP_C)); // R1
    AST_PG_HOLD_INVALID: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(pg_q)); // R9
endmodule

// File: rtl/pwr_seq_gates.sv
module pwr_seq_gates
    import pwr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_s,
    input  logic      run_s,
    input  logic      aux_s,
    input  logic      pg_i,
    output gate_vec_t gates
);
    gate_vec_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= GATES_DARK;
        end else begin
            out_q <= gate_decode(sleep_s, run_s, aux_s, pg_i);
        end
    end

    assign gates = out_q;

    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
        sleep_s |=> (out_q == GATES_DARK)); // R3
    AST_RUN_LOW_STOPS: assert property (@(posedge clk) disable iff (rst)
        (!sleep_s && !run_s) |=> (!out_q.drv_on && !out_q.osc_on && !out_q.ea_on
                                   && out_q.ss_clamp && out_q.ref_on)); // R4
    AST_AUX_INDEPENDENT: assert property (@(posedge clk) disable iff (rst)
        (aux_s && !sleep_s) |=> out_q.aux_on); // R5
    AST_UV_STOPS: assert property (@(posedge clk) disable iff (rst)
        !pg_i |=> (!out_q.drv_on && !out_q.osc_on && !out_q.ea_on && out_q.ss_clamp)); // R6
    AST_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
        (!sleep_s && run_s && pg_i) |=> (out_q.drv_on && !out_q.ss_clamp)); // R7
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
    import pwr_seq_pkg::*;
#(
    parameter int MV_W        = 13,
    parameter int START_MV    = 4100,
    parameter int STOP_MV     = 3500,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_req,
    input  logic            run_en,
    input  logic            aux_req,
    input  logic [MV_W-1:0] vsup_mv,
    input  logic            vsup_valid,
    output logic            pgood,
    output logic            ref_on,
    output logic            osc_on,
    output logic            drv_on,
    output logic            ea_on,
    output logic            ss_clamp,
    output logic            aux_on
);
    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_s;
    logic             pg_state;
    gate_vec_t        gates;

    always_comb begin
        ctl_raw            = '0;
        ctl_raw[CTL_SLEEP] = sleep_req;
        ctl_raw[CTL_RUN]   = run_en;
        ctl_raw[CTL_AUX]   = aux_req;
    end

    pwr_seq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    pwr_seq_uvlo #(.MV_W(MV_W), .START_MV(START_MV), .STOP_MV(STOP_MV)) u_uvlo (
        .clk       (clk),
        .rst       (rst),
        .smp_mv    (vsup_mv),
        .smp_valid (vsup_valid),
        .pg        (pg_state)
    );

    pwr_seq_gates u_gates (
        .clk     (clk),
        .rst     (rst),
        .sleep_s (ctl_s[CTL_SLEEP]),
        .run_s   (ctl_s[CTL_RUN]),
        .aux_s   (ctl_s[CTL_AUX]),
        .pg_i    (pg_state),
        .gates   (gates)
    );

    assign pgood    = gates.pg;
    assign ref_on   = gates.ref_on;
    assign osc_on   = gates.osc_on;
    assign drv_on   = gates.drv_on;
    assign ea_on    = gates.ea_on;
    assign ss_clamp = gates.ss_clamp;
    assign aux_on   = gates.aux_on;

    initial begin
        AST_WINDOW_ORDER: assert (STOP_MV < START_MV); // R1
    end

    AST_DRV_CLAMP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(drv_on && ss_clamp)); // R7
    AST_PGOOD_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        pgood |-> ref_on); // R3
endmodule

// File: tb/pwr_sequencer_tb.sv
module pwr_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_req = 1'b0;
    logic        run_en = 1'b0;
    logic        aux_req = 1'b0;
    logic [12:0] vsup_mv = '0;
    logic        vsup_valid = 1'b0;
    logic        pgood, ref_on, osc_on, drv_on, ea_on, ss_clamp, aux_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_sequencer u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .run_en(run_en),
        .aux_req(aux_req), .vsup_mv(vsup_mv), .vsup_valid(vsup_valid),
        .pgood(pgood), .ref_on(ref_on), .osc_on(osc_on), .drv_on(drv_on),
        .ea_on(ea_on), .ss_clamp(ss_clamp), .aux_on(aux_on)
    );

    // observed order: {ref, pgood, osc, drv, ea, clamp, aux}
    wire [6:0] obs = {ref_on, pgood, osc_on, drv_on, ea_on, ss_clamp, aux_on};

    localparam logic [6:0] P_DARK   = 7'b0000010;
    localparam logic [6:0] P_IDLE   = 7'b1000010; // ref on, supply low
    localparam logic [6:0] P_STOP   = 7'b1100010; // ref+pg, switching off
    localparam logic [6:0] P_RUN    = 7'b1111100;

    task automatic chk(input string req, input string what, input logic [6:0] exp);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, obs, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_ctl(input logic s, input logic e, input logic a);
        @(negedge clk);
        sleep_req = s; run_en = e; aux_req = a;
    endtask

    // one-cycle sample; returns at the negedge after the capturing edge
    task automatic sample(input logic [12:0] mv, input logic v);
        @(negedge clk);
        vsup_mv = mv; vsup_valid = v;
        @(negedge clk);
        vsup_valid = 1'b0;
    endtask

    task automatic t_reset;
        edges(1);
        chk("R2", "in reset", P_DARK);
        @(negedge clk); rst = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b0);
        edges(3);
        chk("R2", "out of reset, no sample", P_IDLE);
        edges(4);
        chk("R6", "supply not yet good", P_IDLE);
    endtask

    task automatic t_hysteresis;
        sample(13'd4100, 1'b1); edges(1);
        chk("R1", "equal to start stays low", P_IDLE);
        sample(13'd5000, 1'b0); edges(1);
        chk("R9", "invalid high sample ignored", P_IDLE);
        sample(13'd4101, 1'b1); edges(1);
        chk("R7", "above start runs", P_RUN);
        sample(13'd3500, 1'b1); edges(1);
        chk("R1", "equal to stop stays high", P_RUN);
        sample(13'd3800, 1'b1); edges(1);
        chk("R1", "inside window holds high", P_RUN);
        sample(13'd100, 1'b0); edges(1);
        chk("R9", "invalid low sample ignored", P_RUN);
        sample(13'd3499, 1'b1); edges(1);
        chk("R6", "below stop shuts down", P_IDLE);
        sample(13'd4000, 1'b1); edges(1);
        chk("R1", "inside window holds low", P_IDLE);
        sample(13'd4200, 1'b1); edges(1);
        chk("R1", "rise again", P_RUN);
    endtask

    task automatic t_latency;
        set_ctl(1'b0, 1'b0, 1'b0);
        edges(2);
        chk("R8", "run drop not before third edge", P_RUN);
        edges(1);
        chk("R8", "run drop on third edge", P_STOP);
        set_ctl(1'b0, 1'b1, 1'b0);
        edges(3);
        chk("R7", "run restored", P_RUN);
        // undervoltage path: sample edge then one more edge
        sample(13'd3000, 1'b1);
        #1;
        chk("R8", "uv not before output edge", P_RUN);
        edges(1);
        chk("R8", "uv on second edge", P_IDLE);
        sample(13'd4500, 1'b1); edges(1);
        chk("R7", "recovered", P_RUN);
    endtask

    task automatic t_run_low;
        set_ctl(1'b0, 1'b0, 1'b1);
        edges(3);
        chk("R4", "run low keeps ref, pg, aux", P_STOP | 7'b0000001);
        set_ctl(1'b0, 1'b0, 1'b0);
        edges(3);
        chk("R4", "run low aux off", P_STOP);
    endtask

    task automatic t_sleep;
        set_ctl(1'b1, 1'b1, 1'b1);
        edges(2);
        chk("R8", "sleep not before third edge", P_STOP);
        edges(1);
        chk("R3", "sleep darkens all, en/aux high", P_DARK);
        set_ctl(1'b1, 1'b0, 1'b0);
        edges(3);
        chk("R3", "sleep with en/aux low", P_DARK);
        sample(13'd5000, 1'b1); edges(2);
        chk("R3", "sleep ignores supply", P_DARK);
        set_ctl(1'b0, 1'b1, 1'b1);
        edges(3);
        chk("R3", "sleep release restores kept pg", P_RUN | 7'b0000001);
    endtask

    task automatic t_aux;
        sample(13'd3000, 1'b1); edges(1);
        chk("R5", "aux alive during undervoltage", P_IDLE | 7'b0000001);
        set_ctl(1'b0, 1'b0, 1'b1);
        edges(3);
        chk("R5", "aux alive with run low and uv", P_IDLE | 7'b0000001);
        set_ctl(1'b0, 1'b0, 1'b0);
        edges(3);
        chk("R5", "aux off when request low", P_IDLE);
    endtask

    task automatic t_collide;
        sample(13'd4500, 1'b1); edges(1);
        chk("R4", "pg high, run low", P_STOP);
        @(negedge clk); run_en = 1'b1;       // synced on 2nd edge from here
        @(negedge clk);                       // after edge 1
        vsup_mv = 13'd3000; vsup_valid = 1'b1; // captured on edge 2
        @(negedge clk); vsup_valid = 1'b0;    // after edge 2
        #1;
        chk("R8", "collision: before output edge", P_STOP);
        edges(1);
        chk("R6", "collision: run and uv same edge, no drive", P_IDLE);
        edges(1);
        chk("R6", "collision: still no drive", P_IDLE);
    endtask

    initial begin
        t_reset();
        t_hysteresis();
        t_latency();
        t_run_low();
        t_sleep();
        t_aux();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule